// File: doc/BRIEF.md
# Half-Duplex Nibble/Byte Transmit Gate

This block sits between a MAC's outgoing byte stream and the transmit pins of an MII-style PHY. It runs on the transmit clock that the PHY supplies. In nibble mode it splits each byte into two 4-bit beats. In byte mode it forwards each byte as one beat. Upstream data arrives through a valid/ready handshake, and a last flag marks the final byte of a frame.

In half duplex it holds a pending frame back while the PHY reports carrier. In every mode it keeps the line idle for a minimum inter-packet gap after each frame ends. Two static configuration inputs select duplex and beat width. Half duplex is accepted only with nibble beats. Half duplex requested together with byte beats is treated as full duplex and is reported on a flag output.

Top module: `mii_tx_defer`

## Requirements
- R1: While reset is high and after it is released, `tx_en` is low and `tx_data` is all zeros. The inter-packet gap counts as satisfied after reset, so the first frame is accepted on the first clock that `in_valid` is high.
- R2: The combination half duplex with byte beats is treated as full duplex, so carrier is ignored. `cfg_illegal` is high one clock after that combination is applied and low one clock after it is removed.
- R3: In half duplex with nibble beats, no frame starts while the synchronized carrier is high. After `crs_in` falls, the first beat appears on `tx_en` three clocks later: two synchronizer stages plus the acceptance register.
- R4: Between two frames, `tx_en` stays low for at least 24 clocks in nibble mode and at least 12 in byte mode, counted from the clock where `tx_en` falls. When the next frame is already waiting, the gap is exactly that length.
- R5: `tx_en` goes high on the clock after the first byte is accepted. It stays high without a break through the last beat of the frame, and it goes low on the next clock. No beats are added after the last one.
- R6: In nibble mode each byte takes two beats, with bits 3:0 first and bits 7:4 second. The nibble appears on `tx_data[3:0]` and `tx_data[7:4]` is zero. `in_ready` is low on the clock after each accepted byte, so within a frame bytes are taken on every other clock.
- R7: In byte mode each accepted byte appears unchanged on `tx_data` one clock later. Within a frame, `in_ready` stays high on every clock.
- R8: In full duplex, carrier has no effect: a frame is accepted on the first clock that `in_valid` is high while `crs_in` is high.
- R9: Once a frame has started, a rise of `crs_in` does not shorten or interrupt it. All of its beats are sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock supplied by the PHY |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_duplex | input | 1 | 1 selects half duplex (honoured only in nibble mode) |
| cfg_nibble_mode | input | 1 | 1 selects 4-bit beats, 0 selects 8-bit beats |
| crs_in | input | 1 | Carrier sense from the PHY, asynchronous |
| in_valid | input | 1 | Upstream byte is valid |
| in_data | input | DW | Upstream byte |
| in_last | input | 1 | Upstream byte ends the frame |
| in_ready | output | 1 | Byte is taken at this clock edge when valid |
| tx_en | output | 1 | Transmit enable to the PHY |
| tx_data | output | DW | Transmit beat; nibble mode uses bits 3:0 |
| cfg_illegal | output | 1 | Half duplex was requested with byte beats |

## Verification
Each result has a fixed latency. A beat is due on the sampling point right after the clock edge that accepts its byte. The high nibble is due one clock after the low nibble. The end of the frame is due one clock after the last beat. A start after carrier falls is due three clocks after the fall, and `cfg_illegal` is due one clock after the configuration changes. The bench drives inputs and reads outputs on the falling edge. It reads `in_ready` one nanosecond later, once the inputs have settled. A monitor compares every high `tx_en` sample with a queue of expected beats, so each beat is checked in the exact clock it is due. The deferral test counts falling edges from the carrier drop and checks for no beat at the second edge and a beat at the third. Gap lengths are counted in low samples between frames and compared exactly whenever the next frame was already waiting.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
  // Clocks needed to cover a gap of gap_bits when each clock carries beat_bits.
  function automatic int gap_clocks(input int gap_bits, input int beat_bits);
    return gap_bits / beat_bits;
  endfunction
endpackage

// File: rtl/hdtx_sync.sv
module hdtx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hdtx_gap.sv
module hdtx_gap #(
  parameter int DW       = 8,
  parameter int GAP_BITS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic line_busy,
  input  logic nibble_mode,
  output logic gap_ok
);
  localparam int NIB_GAP  = hdtx_pkg::gap_clocks(GAP_BITS, DW / 2);
  localparam int BYTE_GAP = hdtx_pkg::gap_clocks(GAP_BITS, DW);
  localparam int CW       = $clog2(NIB_GAP);
  localparam logic [CW-1:0] SAT      = CW'(NIB_GAP - 1);
  localparam logic [CW-1:0] BYTE_MIN = CW'(BYTE_GAP - 1);

  logic [CW-1:0] idle_cnt;

  // Counts clocks since the line went quiet; saturates once the longest gap is met.
  always_ff @(posedge clk) begin
    if (rst)                  idle_cnt <= SAT;
    else if (line_busy)       idle_cnt <= '0;
    else if (idle_cnt != SAT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign gap_ok = idle_cnt >= (nibble_mode ? SAT : BYTE_MIN);
endmodule

// File: rtl/mii_tx_defer.sv
module mii_tx_defer #(
  parameter int DW          = 8,
  parameter int GAP_BITS    = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_half_duplex,
  input  logic          cfg_nibble_mode,
  input  logic          crs_in,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          tx_en,
  output logic [DW-1:0] tx_data,
  output logic          cfg_illegal
);
  localparam int HW = DW / 2;

  logic          crs_s;
  logic          gap_ok;
  logic          busy;
  logic          hi_pending;
  logic          last_taken;
  logic [HW-1:0] hi_q;
  logic          half_eff;
  logic          start_ok;
  logic          take;

  hdtx_sync #(.STAGES(SYNC_STAGES)) u_crs_sync (
    .clk (clk),
    .rst (rst),
    .d   (crs_in),
    .q   (crs_s)
  );

  hdtx_gap #(.DW(DW), .GAP_BITS(GAP_BITS)) u_gap (
    .clk         (clk),
    .rst         (rst),
    .line_busy   (tx_en),
    .nibble_mode (cfg_nibble_mode),
    .gap_ok      (gap_ok)
  );

  // Half duplex only counts with nibble beats.
  assign half_eff = cfg_half_duplex & cfg_nibble_mode;
  assign start_ok = !busy && gap_ok && !(half_eff && crs_s);
  assign in_ready = start_ok || (busy && !last_taken && !hi_pending);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      hi_pending  <= 1'b0;
      last_taken  <= 1'b0;
      hi_q        <= '0;
      tx_en       <= 1'b0;
      tx_data     <= '0;
      cfg_illegal <= 1'b0;
    end else begin
      cfg_illegal <= cfg_half_duplex & ~cfg_nibble_mode;
      if (take) begin
        busy       <= 1'b1;
        tx_en      <= 1'b1;
        last_taken <= in_last;
        if (cfg_nibble_mode) begin
          tx_data    <= {{(DW-HW){1'b0}}, in_data[HW-1:0]};
          hi_q       <= in_data[DW-1:HW];
          hi_pending <= 1'b1;
        end else begin
          tx_data    <= in_data;
          hi_pending <= 1'b0;
        end
      end else if (hi_pending) begin
        tx_data    <= {{(DW-HW){1'b0}}, hi_q};
        hi_pending <= 1'b0;
      end else begin
        busy       <= 1'b0;
        last_taken <= 1'b0;
        tx_en      <= 1'b0;
        tx_data    <= '0;
      end
    end
  end
endmodule

// File: rtl/hdtx_checker.sv
module hdtx_checker #(
  parameter int DW       = 8,
  parameter int GAP_BITS = 96
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_half_duplex,
  input logic          cfg_nibble_mode,
  input logic          crs_in,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          in_ready,
  input logic          tx_en,
  input logic [DW-1:0] tx_data,
  input logic          cfg_illegal
);
  localparam int HW       = DW / 2;
  localparam int NIB_GAP  = hdtx_pkg::gap_clocks(GAP_BITS, HW);
  localparam int BYTE_GAP = hdtx_pkg::gap_clocks(GAP_BITS, DW);

  logic [7:0] quiet_cnt;
  logic       took;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)                    quiet_cnt <= 8'hFF;
    else if (tx_en)             quiet_cnt <= 8'h00;
    else if (quiet_cnt != 8'hFF) quiet_cnt <= quiet_cnt + 8'h01;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!tx_en && tx_data == '0));

  assert_illegal_set_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_half_duplex && !cfg_nibble_mode) |=> cfg_illegal);

  assert_illegal_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_half_duplex && !cfg_nibble_mode) |=> !cfg_illegal);

  assert_defer_carrier_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && $past(cfg_half_duplex && cfg_nibble_mode)) |-> !$past(crs_in, 3));

  assert_min_gap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (int'(quiet_cnt) >= ($past(cfg_nibble_mode) ? NIB_GAP : BYTE_GAP)));

  assert_low_nibble_R6: assert property (@(posedge clk) disable iff (rst)
    (took && cfg_nibble_mode) |=>
      (tx_en && tx_data[DW-1:HW] == '0 && tx_data[HW-1:0] == $past(in_data[HW-1:0])));

  assert_high_nibble_R6: assert property (@(posedge clk) disable iff (rst)
    (took && cfg_nibble_mode) |=> !in_ready ##1
      (tx_en && tx_data[HW-1:0] == $past(in_data[DW-1:HW], 2)));

  assert_byte_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (took && !cfg_nibble_mode) |=> (tx_en && tx_data == $past(in_data)));
endmodule

bind mii_tx_defer hdtx_checker #(.DW(DW), .GAP_BITS(GAP_BITS)) u_hdtx_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_half_duplex (cfg_half_duplex),
  .cfg_nibble_mode (cfg_nibble_mode),
  .crs_in          (crs_in),
  .in_valid        (in_valid),
  .in_data         (in_data),
  .in_ready        (in_ready),
  .tx_en           (tx_en),
  .tx_data         (tx_data),
  .cfg_illegal     (cfg_illegal)
);

// File: tb/mii_tx_defer_tb.sv
module mii_tx_defer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_half = 1'b0;
  logic       cfg_nib = 1'b1;
  logic       crs = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       tx_en;
  logic [7:0] tx_data;
  logic       cfg_illegal;

  always #5 clk = ~clk;

  mii_tx_defer u_dut (
    .clk             (clk),
    .rst             (rst),
    .cfg_half_duplex (cfg_half),
    .cfg_nibble_mode (cfg_nib),
    .crs_in          (crs),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .in_last         (in_last),
    .in_ready        (in_ready),
    .tx_en           (tx_en),
    .tx_data         (tx_data),
    .cfg_illegal     (cfg_illegal)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];
  bit mon_on = 1'b0;
  bit exact_gap = 1'b0;
  int cur_gap = 24;
  bit prev_en = 1'b0;
  bit prev_last = 1'b0;
  int low_run = 0;
  int frames_seen = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gap_for(input bit nib);
    return nib ? 24 : 12;
  endfunction

  // Monitor: every beat is compared in the clock it appears.
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      if (tx_en) begin
        if (!prev_en) begin
          if (frames_seen > 0) begin
            if (exact_gap) chk(low_run == cur_gap, "R4", "exact idle gap", low_run, cur_gap);
            else           chk(low_run >= cur_gap, "R4", "minimum idle gap", low_run, cur_gap);
          end
          frames_seen++;
          low_run = 0;
        end else if (prev_last) begin
          chk(1'b0, "R5", "beat after last beat", 1, 0);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected beat", int'(tx_data), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e[7:0], cfg_nib ? "R6" : "R7", "beat value", int'(tx_data), int'(e[7:0]));
          prev_last = e[8];
        end
      end else begin
        if (prev_en && !prev_last) chk(1'b0, "R5", "frame ended early", 0, 1);
        low_run++;
      end
      prev_en = tx_en;
    end
  end

  task automatic put_frame(input int n, output bit first_rdy, output int stalls);
    first_rdy = 1'b0;
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      bit got;
      int tries;
      b = 8'($urandom);
      if (cfg_nib) begin
        exp_q.push_back({1'b0, 4'h0, b[3:0]});
        exp_q.push_back({(i == n - 1), 4'h0, b[7:4]});
      end else begin
        exp_q.push_back({(i == n - 1), b});
      end
      in_valid = 1'b1;
      in_data  = b;
      in_last  = (i == n - 1);
      got = 1'b0;
      tries = 0;
      while (!got) begin
        #1;
        if (in_ready) begin
          got = 1'b1;
          if (i == 0 && tries == 0) first_rdy = 1'b1;
        end else if (i > 0) begin
          stalls++;
        end
        tries++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || tx_en);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit fr;
    int st;
    int seed;
    seed = $urandom(32'd2024);
    if (seed < 0) seed = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!tx_en, "R1", "tx_en in reset", int'(tx_en), 0);
    chk(tx_data == 8'h00, "R1", "tx_data in reset", int'(tx_data), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk(!tx_en && tx_data == 8'h00, "R1", "idle after reset", int'(tx_en), 0);
    chk(!cfg_illegal, "R2", "flag low for full nibble", int'(cfg_illegal), 0);

    // R1: first frame needs no gap; R6 nibble stalls
    cur_gap = 24;
    put_frame(4, fr, st);
    chk(fr, "R1", "first byte taken at once", int'(fr), 1);
    chk(st == 3, "R6", "ready every other clock", st, 3);

    // R4 R7: back-to-back byte frames
    cfg_nib = 1'b0;
    cur_gap = 12;
    exact_gap = 1'b0;
    put_frame(3, fr, st);
    exact_gap = 1'b1;
    put_frame(5, fr, st);
    chk(st == 0, "R7", "no stalls in byte mode", st, 0);
    wait_idle();

    // R4 R6: back-to-back nibble frames
    cfg_nib = 1'b1;
    cur_gap = 24;
    exact_gap = 1'b0;
    put_frame(2, fr, st);
    exact_gap = 1'b1;
    put_frame(3, fr, st);
    wait_idle();

    // R3: deferral while carrier is high
    exact_gap = 1'b0;
    cfg_half = 1'b1;
    crs = 1'b1;
    repeat (4) @(negedge clk);
    fork
      put_frame(2, fr, st);
      begin
        repeat (20) @(negedge clk);
        chk(!tx_en, "R3", "held while carrier high", int'(tx_en), 0);
        chk(!in_ready, "R3", "not ready while carrier high", int'(in_ready), 0);
        crs = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!tx_en, "R3", "no beat two clocks after drop", int'(tx_en), 0);
        @(negedge clk);
        chk(tx_en, "R3", "beat three clocks after drop", int'(tx_en), 1);
      end
    join
    wait_idle();

    // R9: carrier rising mid-frame
    fork
      put_frame(6, fr, st);
      begin
        do @(negedge clk); while (!tx_en);
        repeat (2) @(negedge clk);
        crs = 1'b1;
      end
    join
    wait_idle();
    chk(exp_q.size() == 0 && !tx_en, "R9", "frame completed despite carrier", exp_q.size(), 0);

    // R8: full duplex ignores carrier
    cfg_half = 1'b0;
    repeat (30) @(negedge clk);
    put_frame(3, fr, st);
    chk(fr, "R8", "taken at once with carrier high", int'(fr), 1);
    wait_idle();

    // R2: half duplex with byte beats
    cfg_half = 1'b1;
    cfg_nib = 1'b0;
    cur_gap = 12;
    @(negedge clk);
    chk(cfg_illegal, "R2", "flag one clock after setting", int'(cfg_illegal), 1);
    repeat (20) @(negedge clk);
    put_frame(3, fr, st);
    chk(fr, "R2", "treated as full duplex", int'(fr), 1);
    wait_idle();
    cfg_nib = 1'b1;
    cur_gap = 24;
    @(negedge clk);
    chk(!cfg_illegal, "R2", "flag clears one clock later", int'(cfg_illegal), 0);
    crs = 1'b0;
    repeat (30) @(negedge clk);

    // Random frames, modes and lengths, carrier low
    for (int k = 0; k < 40; k++) begin
      cfg_half = 1'($urandom);
      cfg_nib  = 1'($urandom);
      cur_gap  = gap_for(cfg_nib);
      exact_gap = (k > 0);
      put_frame(1 + int'($urandom % 7), fr, st);
      wait_idle();
    end
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all expected beats seen", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule